// File: doc/BRIEF.md
# Processor Reset and Status Unit

This block keeps the flag state of an 8-bit processor and brings the core out of reset. The six architectural flags are negative, overflow, decimal, interrupt-disable, zero and carry. The block packs them into a status byte that a stack push can store. It also restores them from a byte pulled off the stack.

When reset is released, the unit reads a 16-bit start address from a fixed vector location. It uses a synchronous memory read port: an address is presented in one cycle and the data comes back in the next. The fetched word goes into the program counter. The stack pointer starts at 0xFF, and interrupts start masked. A `ready` flag tells the rest of the core when it may begin fetching instructions. The vector addresses for the non-maskable and the maskable interrupt are driven as constants, for use by the interrupt logic elsewhere.

Top module: `rsu_top`

## Requirements
- R1: Bit 5 of `statusByte` is always 1, whatever was written to the flags or pulled.
- R2: `statusByte` layout: N in bit 7, V in bit 6, D in bit 3, I in bit 2, Z in bit 1, C in bit 0, and bit 4 equal to the `pushBrk` input.
- R3: While reset is asserted: `ready` is 0, `pcOut` is 0x0000, `spOut` is 0xFF, I is 1, and all other flags are 0. With `pushBrk`=0, `statusByte` reads 0x24.
- R4: After reset is released, `memRdEn` is high for exactly two consecutive cycles. The first read presents address 0xFFFC and the second presents 0xFFFD. Read data is taken one cycle after its request.
- R5: The vector is little-endian. `pcOut` becomes {byte from 0xFFFD, byte from 0xFFFC} four clock edges after reset is released, and it then holds.
- R6: `ready` rises one clock edge after the program counter is loaded, stays high until the next reset, and no memory read is made while it is high.
- R7: Flag writes and pulls made before `ready` is high have no effect.
- R8: When `pullEn` is high (and `ready` is high), the flags take bits 7, 6, 3, 2, 1 and 0 of `pullData` at the clock edge. Bits 5 and 4 of `pullData` are ignored.
- R9: `flagWe[k]` loads `flagWd[k]` into the flag at bit position k at the clock edge. For that bit, this takes priority over a pull in the same cycle. Enables for bits 5 and 4 are ignored.
- R10: `nmiVec` reads 0xFFFA and `irqVec` reads 0xFFFE.
- R11: A second reset puts the flags and stack pointer back to their reset state and fetches the vector again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memRdEn | output | 1 | Read request to memory |
| memAddr | output | 16 | Read address |
| memRdData | input | 8 | Read data, valid the cycle after the request |
| pushBrk | input | 1 | Value shown in bit 4 of the packed byte |
| flagWe | input | 8 | Per-bit flag write enables, by byte position |
| flagWd | input | 8 | Per-bit flag write data, by byte position |
| pullEn | input | 1 | Restore flags from `pullData` |
| pullData | input | 8 | Status byte pulled from the stack |
| statusByte | output | 8 | Packed flags for a push |
| pcOut | output | 16 | Program counter loaded from the vector |
| spOut | output | 8 | Stack pointer |
| nmiVec | output | 16 | Non-maskable interrupt vector address |
| irqVec | output | 16 | Maskable interrupt vector address |
| ready | output | 1 | Start-up done |

## Verification
The hardest situation to create is a flag update that arrives during the start-up window, which must leave no trace. The reset task holds every flag write enable and the pull strobe active, with data that would clear the interrupt-disable flag. It keeps them active through the whole vector fetch and drops them only in the cycle just before `ready` rises. It then checks that the packed byte still holds its reset value. The same task checks the read address and the program counter one edge at a time, so that an off-by-one in the fetch sequence shows up as a wrong value at a named edge.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  localparam int BIT_N   = 7;
  localparam int BIT_V   = 6;
  localparam int BIT_ONE = 5;
  localparam int BIT_B   = 4;
  localparam int BIT_D   = 3;
  localparam int BIT_I   = 2;
  localparam int BIT_Z   = 1;
  localparam int BIT_C   = 0;

  localparam int FLAG_CNT = 6;

  // byte position of the k-th stored flag
  function automatic int flagPos(input int k);
    case (k)
      0:       flagPos = BIT_C;
      1:       flagPos = BIT_Z;
      2:       flagPos = BIT_I;
      3:       flagPos = BIT_D;
      4:       flagPos = BIT_V;
      default: flagPos = BIT_N;
    endcase
  endfunction

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_LOAD,
    ST_SETTLE,
    ST_RUN
  } rsuState_t;

  typedef struct packed {
    logic rdEn;
    logic rdHi;
    logic capLo;
    logic loadPc;
    logic ready;
  } rsuStrobe_t;

endpackage

// File: rtl/rsu_ctrl.sv
module rsu_ctrl
  import rsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  output rsuStrobe_t strobe
);

  rsuState_t state;
  rsuState_t stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  always_comb begin
    case (state)
      ST_HOLD:     stateNxt = ST_FETCH_LO;
      ST_FETCH_LO: stateNxt = ST_FETCH_HI;
      ST_FETCH_HI: stateNxt = ST_LOAD;
      ST_LOAD:     stateNxt = ST_SETTLE;
      ST_SETTLE:   stateNxt = ST_RUN;
      default:     stateNxt = ST_RUN;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = (state == ST_FETCH_LO) || (state == ST_FETCH_HI);
    strobe.rdHi   = (state == ST_FETCH_HI);
    strobe.capLo  = (state == ST_FETCH_HI);
    strobe.loadPc = (state == ST_LOAD);
    strobe.ready  = (state == ST_RUN);
  end

endmodule

// File: rtl/rsu_datapath.sv
module rsu_datapath
  import rsu_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  parameter logic [7:0]  SP_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsuStrobe_t        strobe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              pushBrk,
  input  logic [DATA_W-1:0] flagWe,
  input  logic [DATA_W-1:0] flagWd,
  input  logic              pullEn,
  input  logic [DATA_W-1:0] pullData,
  output logic [DATA_W-1:0] statusByte,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut
);

  localparam logic [ADDR_W-1:0] VEC_LO = ADDR_W'(RST_VEC);
  localparam logic [ADDR_W-1:0] VEC_HI = ADDR_W'(RST_VEC) + ADDR_W'(1);

  logic [DATA_W-1:0] loByte;
  logic [FLAG_CNT-1:0] flagQ;
  logic unusedBits;

  assign unusedBits = ^{flagWe[BIT_ONE], flagWe[BIT_B], flagWd[BIT_ONE],
                        flagWd[BIT_B], pullData[BIT_ONE], pullData[BIT_B]};

  assign memAddr = strobe.rdHi ? VEC_HI : VEC_LO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte <= '0;
      pcOut  <= '0;
      spOut  <= SP_INIT;
    end else begin
      if (strobe.capLo)  loByte <= memRdData;
      if (strobe.loadPc) begin
        pcOut <= {memRdData, loByte};
        spOut <= SP_INIT;
      end
    end
  end

  for (genvar k = 0; k < FLAG_CNT; k++) begin : g_flag
    localparam int  POS = flagPos(k);
    localparam logic RST_VAL = (POS == BIT_I);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[k] <= RST_VAL;
      end else if (strobe.ready) begin
        if (flagWe[POS])  flagQ[k] <= flagWd[POS];
        else if (pullEn)  flagQ[k] <= pullData[POS];
      end
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[BIT_ONE] = 1'b1;
    statusByte[BIT_B]   = pushBrk;
    for (int k = 0; k < FLAG_CNT; k++) begin
      statusByte[flagPos(k)] = flagQ[k];
    end
  end

endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] NMI_VEC = 16'hFFFA,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              pushBrk,
  input  logic [DATA_W-1:0] flagWe,
  input  logic [DATA_W-1:0] flagWd,
  input  logic              pullEn,
  input  logic [DATA_W-1:0] pullData,
  output logic [DATA_W-1:0] statusByte,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [ADDR_W-1:0] nmiVec,
  output logic [ADDR_W-1:0] irqVec,
  output logic              ready
);

  rsuStrobe_t strobe;

  rsu_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  rsu_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RST_VEC (RST_VEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .memAddr    (memAddr),
    .memRdData  (memRdData),
    .pushBrk    (pushBrk),
    .flagWe     (flagWe),
    .flagWd     (flagWd),
    .pullEn     (pullEn),
    .pullData   (pullData),
    .statusByte (statusByte),
    .pcOut      (pcOut),
    .spOut      (spOut)
  );

  assign memRdEn = strobe.rdEn;
  assign ready   = strobe.ready;
  assign nmiVec  = ADDR_W'(NMI_VEC);
  assign irqVec  = ADDR_W'(IRQ_VEC);

endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
  parameter logic [15:0] RST_VEC = 16'hFFFC
) (
  input logic        clk,
  input logic        rstN,
  input logic        memRdEn,
  input logic [15:0] memAddr,
  input logic        pushBrk,
  input logic [7:0]  flagWe,
  input logic [7:0]  flagWd,
  input logic        pullEn,
  input logic [7:0]  pullData,
  input logic [7:0]  statusByte,
  input logic [15:0] pcOut,
  input logic [7:0]  spOut,
  input logic        ready
);

  AST_BIT5_SET: assert property (@(posedge clk) disable iff (!rstN) statusByte[5]); // R1
  AST_BRK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) statusByte[4] == pushBrk); // R2
  AST_STARTUP_FROZEN: assert property (@(posedge clk) disable iff (!rstN) !ready |-> (spOut == 8'hFF && statusByte[2])); // R7
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rstN) memRdEn |-> (memAddr == RST_VEC || memAddr == RST_VEC + 16'd1)); // R4
  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rstN) (memRdEn && memAddr == RST_VEC) |=> (memRdEn && memAddr == RST_VEC + 16'd1)); // R4
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN) ready |=> ready); // R6
  AST_READY_LATE: assert property (@(posedge clk) disable iff (!rstN) $rose(ready) |-> ($past(memRdEn, 3) && $past(memAddr, 3) == RST_VEC + 16'd1)); // R6
  AST_NO_READ_RUN: assert property (@(posedge clk) disable iff (!rstN) ready |-> !memRdEn); // R6
  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rstN) ready |=> $stable(pcOut)); // R5
  AST_PULL_MASK: assert property (@(posedge clk) disable iff (!rstN) (ready && pullEn && flagWe == 8'h00) |=> (statusByte[7:6] == $past(pullData[7:6]) && statusByte[3:0] == $past(pullData[3:0]))); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN) (ready && flagWe[0]) |=> statusByte[0] == $past(flagWd[0])); // R9
  AST_NO_BIT_WRITE: assert property (@(posedge clk) disable iff (!rstN) (ready && !pullEn && flagWe[7:6] == 2'b00 && flagWe[3:0] == 4'h0 && (flagWe[5:4] != 2'b00 || flagWd != 8'h00)) |=> $stable({statusByte[7:6], statusByte[3:0]})); // R9

endmodule

bind rsu_top rsu_checker #(.RST_VEC(RST_VEC)) u_chk (.*);

// File: tb/rsu_top_bench.sv
`timescale 1ns/1ps
module rsu_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData = 8'h00;
  logic        pushBrk = 1'b0;
  logic [7:0]  flagWe = 8'h00;
  logic [7:0]  flagWd = 8'h00;
  logic        pullEn = 1'b0;
  logic [7:0]  pullData = 8'h00;
  logic [7:0]  statusByte;
  logic [15:0] pcOut;
  logic [7:0]  spOut;
  logic [15:0] nmiVec;
  logic [15:0] irqVec;
  logic        ready;

  logic [7:0] vecLo = 8'h00;
  logic [7:0] vecHi = 8'h04;
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rsu_top u_rsu_top (.*);

  // synchronous memory model: data one cycle after request
  always @(posedge clk) begin
    if (memRdEn) begin
      if (memAddr == 16'hFFFC)      memRdData <= vecLo;
      else if (memAddr == 16'hFFFD) memRdData <= vecHi;
      else                          memRdData <= 8'hEE;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tResetSeq(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    vecLo = lo; vecHi = hi;
    rstN = 1'b0;
    pushBrk = 1'b0;
    // R7: updates held active through start-up
    flagWe = 8'hFF; flagWd = 8'h00; pullEn = 1'b1; pullData = 8'h00;
    stepEdge(); stepEdge();
    chk("R3 ready in reset", ready, 0);
    chk("R3 pc in reset", pcOut, 16'h0000);
    chk("R3 sp in reset", spOut, 8'hFF);
    chk("R3 status in reset", statusByte, 8'h24);
    rstN = 1'b1;
    stepEdge();
    chk("R4 first read enable", memRdEn, 1);
    chk("R4 first read addr", memAddr, 16'hFFFC);
    stepEdge();
    chk("R4 second read enable", memRdEn, 1);
    chk("R4 second read addr", memAddr, 16'hFFFD);
    stepEdge();
    chk("R4 reads stop", memRdEn, 0);
    chk("R6 not ready early", ready, 0);
    stepEdge();
    chk("R5 pc little-endian", pcOut, {hi, lo});
    chk("R6 ready one edge after pc", ready, 0);
    flagWe = 8'h00; pullEn = 1'b0;
    stepEdge();
    chk("R6 ready high", ready, 1);
    chk("R7 startup writes ignored", statusByte, 8'h24);
    chk("R3 sp after start", spOut, 8'hFF);
    stepEdge(); stepEdge();
    chk("R6 ready sticks", ready, 1);
    chk("R5 pc holds", pcOut, {hi, lo});
  endtask

  task automatic tPack();
    flagWe = 8'hFF; flagWd = 8'hFF; stepEdge();
    flagWe = 8'h00;
    chk("R2 all flags set", statusByte, 8'hEF);
    pushBrk = 1'b1; #1;
    chk("R2 brk bit", statusByte, 8'hFF);
    pushBrk = 1'b0;
    flagWe = 8'hFF; flagWd = 8'h00; stepEdge();
    flagWe = 8'h00;
    chk("R1 bit5 stays high", statusByte, 8'h20);
    flagWe = 8'h80; flagWd = 8'h80; stepEdge();
    chk("R2 negative at bit7", statusByte, 8'hA0);
    flagWe = 8'h01; flagWd = 8'h01; stepEdge();
    chk("R2 carry at bit0", statusByte, 8'hA1);
    flagWe = 8'h30; flagWd = 8'h00; stepEdge();
    flagWe = 8'h00;
    chk("R9 enables 5/4 ignored", statusByte, 8'hA1);
  endtask

  task automatic tPull();
    pullEn = 1'b1; pullData = 8'h30; stepEdge();
    chk("R8 pull ignores bits 5/4", statusByte, 8'h20);
    pullData = 8'hCF; stepEdge();
    chk("R8 pull all flags", statusByte, 8'hEF);
    pullData = 8'h5A; stepEdge();
    chk("R8 pull mixed", statusByte, 8'h6A);
    pullData = 8'h00; flagWe = 8'h01; flagWd = 8'h01; stepEdge();
    chk("R9 write beats pull", statusByte, 8'h21);
    pullEn = 1'b0; flagWe = 8'h00;
  endtask

  task automatic tVectors();
    chk("R10 nmi vector", nmiVec, 16'hFFFA);
    chk("R10 irq vector", irqVec, 16'hFFFE);
  endtask

  initial begin
    tResetSeq(8'h00, 8'h04);
    tPack();
    tPull();
    tVectors();
    // R11: second reset with different vector after dirty flags
    flagWe = 8'hFF; flagWd = 8'h00; stepEdge(); flagWe = 8'h00;
    tResetSeq(8'h34, 8'h12);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule